// File: doc/BRIEF.md
# Bank-Parity Broadcast Mode Controller for In-Memory Processing

This block sits between a memory command port and the sixteen banks of one pseudo-channel. It keeps a small mode state and uses it to decide which banks a read or write reaches, where read data goes and where write data comes from. The host changes the mode by writing to a reserved row. No other control path exists.

In single-bank mode a command reaches only the bank it addresses. In the broadcast mode a command reaches every bank that has the same parity as the addressed bank. The other bank-index bits are ignored. In the processing mode the broadcast is the same, and the processing units also receive the command. Each unit serves one even bank and one odd bank. On a read the processing units get the row and column address and the data from the selected banks. On a write the banks store the processing units' results, and the host data is thrown away. Commands complete in the same cycle. Only the mode register holds state.

Top module: `pim_mode_ctrl`

## Requirements
- R1: After reset, `mode_o` is 0 (single-bank) and `mode_err` is 0. `mode_o` only ever takes the codes 0 (single-bank), 1 (broadcast) and 2 (processing).
- R2: In single-bank mode, a valid command whose row is not the reserved row sets exactly bit `cmd_bank` of `bank_en`. Every bank's `bank_wdata` slice carries `cmd_wdata`.
- R3: In modes 1 and 2, a valid non-reserved command sets `bank_en[b]` for every b with b mod 2 equal to `cmd_bank[0]`, and clears all other bits. Bits 3..1 of `cmd_bank` have no effect.
- R4: In modes 1 and 2, a read returns on `rd_data` the data of bank `cmd_bank[0]`, which is the lowest-numbered bank of the selected parity.
- R5: In mode 2, `pu_valid` is high for each valid non-reserved command. `pu_row`, `pu_col` and `pu_we` follow the command, and `pu_odd` equals `cmd_bank[0]`. On a read, slice k of `pu_rdata` equals the data of bank 2k+`cmd_bank[0]`.
- R6: In mode 2, the `bank_wdata` slice of bank b equals slice b/2 (rounded down) of `pu_wdata`, whatever the value of `cmd_wdata`.
- R7: A valid write to the reserved row (all ones) requests a mode change, which takes effect at the next clock edge. Column 0 selects mode 0, column 1 selects mode 1 and column 2 selects mode 2. Any command to the reserved row enables no bank and does not assert `pu_valid`.
- R8: Two mode requests are illegal: a request for mode 2 made from mode 0, and a request with any other column value. An illegal request leaves the mode unchanged and raises `mode_err` for exactly one cycle after the edge. Mode 2 is therefore only ever entered from mode 1.
- R9: Outside mode 2, `pu_valid` stays low.
- R10: In single-bank mode, a read returns on `rd_data` the data of bank `cmd_bank`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_we | input | 1 | 1 for write, 0 for read |
| cmd_bank | input | 4 | Bank index of the command |
| cmd_row | input | 14 | Row address; all ones is the reserved mode row |
| cmd_col | input | 5 | Column address; selects the target mode on the reserved row |
| cmd_wdata | input | 256 | Host write data |
| bank_rdata | input | 4096 | Read data of all banks, bank b at bits b*256 and up |
| pu_wdata | input | 2048 | Processing-unit results, unit k at bits k*256 and up |
| bank_en | output | 16 | Per-bank command enable |
| bank_we | output | 1 | Write strobe for the enabled banks |
| bank_row | output | 14 | Row address to the banks |
| bank_col | output | 5 | Column address to the banks |
| bank_wdata | output | 4096 | Per-bank write data |
| rd_data | output | 256 | Read data returned to the host |
| pu_valid | output | 1 | Command forwarded to the processing units |
| pu_we | output | 1 | Forwarded command is a write |
| pu_odd | output | 1 | Parity of the banks in use |
| pu_row | output | 14 | Row address to the processing units |
| pu_col | output | 5 | Column address to the processing units |
| pu_rdata | output | 2048 | Bank data to the processing units, unit k at bits k*256 and up |
| mode_o | output | 2 | Current mode code |
| mode_err | output | 1 | One-cycle pulse after an illegal mode request |

## Verification
The mode register is the only state, so the effect of a wrong value shows on the next command, in the same cycle as that command.
- A lost transition gives an enable pattern with one bit set where a parity half was expected, or the reverse.
- A wrong broadcast decode enables a bank of the wrong parity.
- A processing mode entered where it should not be turns on `pu_valid` and replaces the host's write data with processing-unit data on the bank side.

Illegal requests must leave `mode_o` unchanged on the next edge and raise a single-cycle `mode_err`.

// File: rtl/pim_mode_ctrl.sv
module pim_mode_ctrl #(
  parameter int NUM_BANKS = 16,
  parameter int DATA_W = 256,
  parameter int ROW_W = 14,
  parameter int COL_W = 5,
  parameter logic [ROW_W-1:0] MODE_ROW = '1,
  parameter logic [COL_W-1:0] COL_TO_SB = 5'd0,
  parameter logic [COL_W-1:0] COL_TO_AB = 5'd1,
  parameter logic [COL_W-1:0] COL_TO_ABP = 5'd2,
  localparam int BANK_W = $clog2(NUM_BANKS),
  localparam int NUM_PU = NUM_BANKS / 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cmd_valid,
  input  logic                        cmd_we,
  input  logic [BANK_W-1:0]           cmd_bank,
  input  logic [ROW_W-1:0]            cmd_row,
  input  logic [COL_W-1:0]            cmd_col,
  input  logic [DATA_W-1:0]           cmd_wdata,
  input  logic [NUM_BANKS*DATA_W-1:0] bank_rdata,
  input  logic [NUM_PU*DATA_W-1:0]    pu_wdata,
  output logic [NUM_BANKS-1:0]        bank_en,
  output logic                        bank_we,
  output logic [ROW_W-1:0]            bank_row,
  output logic [COL_W-1:0]            bank_col,
  output logic [NUM_BANKS*DATA_W-1:0] bank_wdata,
  output logic [DATA_W-1:0]           rd_data,
  output logic                        pu_valid,
  output logic                        pu_we,
  output logic                        pu_odd,
  output logic [ROW_W-1:0]            pu_row,
  output logic [COL_W-1:0]            pu_col,
  output logic [NUM_PU*DATA_W-1:0]    pu_rdata,
  output logic [1:0]                  mode_o,
  output logic                        mode_err
);

  typedef enum logic [1:0] {M_SB = 2'd0, M_AB = 2'd1, M_ABP = 2'd2} mode_t;

  mode_t mode_q, mode_nx;
  logic  req_bad;

  wire is_resv  = (cmd_row == MODE_ROW);
  wire mode_wr  = cmd_valid && cmd_we && is_resv;
  wire data_cmd = cmd_valid && !is_resv;
  wire single   = (mode_q == M_SB);
  wire proc     = (mode_q == M_ABP);

  always_comb begin
    mode_nx = mode_q;
    req_bad = 1'b0;
    if (cmd_col == COL_TO_SB) mode_nx = M_SB;
    else if (cmd_col == COL_TO_AB) mode_nx = M_AB;
    else if (cmd_col == COL_TO_ABP) begin
      if (mode_q == M_SB) req_bad = 1'b1;
      else mode_nx = M_ABP;
    end else req_bad = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= M_SB;
      mode_err <= 1'b0;
    end else begin
      mode_err <= mode_wr && req_bad;
      if (mode_wr && !req_bad) mode_q <= mode_nx;
    end
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign bank_en[b] = data_cmd &&
      (single ? (cmd_bank == BANK_W'(b)) : (cmd_bank[0] == 1'((b % 2))));
    assign bank_wdata[b*DATA_W +: DATA_W] =
      proc ? pu_wdata[(b/2)*DATA_W +: DATA_W] : cmd_wdata;
  end

  for (genvar k = 0; k < NUM_PU; k++) begin : g_pu
    assign pu_rdata[k*DATA_W +: DATA_W] = cmd_bank[0] ?
      bank_rdata[(2*k+1)*DATA_W +: DATA_W] : bank_rdata[(2*k)*DATA_W +: DATA_W];
  end

  wire [BANK_W-1:0] rd_sel = single ? cmd_bank : {{(BANK_W-1){1'b0}}, cmd_bank[0]};

  assign rd_data  = bank_rdata[rd_sel*DATA_W +: DATA_W];
  assign bank_we  = cmd_we;
  assign bank_row = cmd_row;
  assign bank_col = cmd_col;
  assign pu_valid = data_cmd && proc;
  assign pu_we    = cmd_we;
  assign pu_odd   = cmd_bank[0];
  assign pu_row   = cmd_row;
  assign pu_col   = cmd_col;
  assign mode_o   = mode_q;

endmodule

// File: rtl/pim_mode_ctrl_chk.sv
module pim_mode_ctrl_chk #(
  parameter int NUM_BANKS = 16,
  parameter int ROW_W = 14,
  parameter logic [ROW_W-1:0] MODE_ROW = '1
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cmd_valid,
  input logic [ROW_W-1:0]     cmd_row,
  input logic [NUM_BANKS-1:0] bank_en,
  input logic                 pu_valid,
  input logic [1:0]           mode_o,
  input logic                 mode_err
);

  p_code_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
    mode_o != 2'd3);

  p_single_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mode_o == 2'd0 |-> $onehot0(bank_en));

  p_bcast_half_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mode_o != 2'd0 |-> ($countones(bank_en) == 0 || $countones(bank_en) == NUM_BANKS/2));

  p_resv_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_row == MODE_ROW) |-> (bank_en == '0 && !pu_valid));

  p_proc_entry_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'd2 && $past(mode_o) != 2'd2) |-> $past(mode_o) == 2'd1);

  p_err_keeps_mode_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mode_err |-> mode_o == $past(mode_o));

  p_pu_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mode_o != 2'd2 |-> !pu_valid);

endmodule

bind pim_mode_ctrl pim_mode_ctrl_chk #(
  .NUM_BANKS(NUM_BANKS), .ROW_W(ROW_W), .MODE_ROW(MODE_ROW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_row(cmd_row),
  .bank_en(bank_en), .pu_valid(pu_valid), .mode_o(mode_o), .mode_err(mode_err)
);

// File: tb/sim_pim_mode_ctrl.sv
module sim_pim_mode_ctrl;
  localparam int CLK_P = 10;
  localparam int NB = 16;
  localparam int DW = 256;
  localparam int RW = 14;
  localparam int CW = 5;
  localparam int NPU = NB / 2;
  localparam logic [RW-1:0] MROW = '1;

  logic clk = 0, rst_n = 0;
  logic c_valid = 0, c_we = 0;
  logic [3:0] c_bank = '0;
  logic [RW-1:0] c_row = '0;
  logic [CW-1:0] c_col = '0;
  logic [DW-1:0] c_wdata = '0;
  logic [NB*DW-1:0] b_rdata = '0;
  logic [NPU*DW-1:0] p_wdata = '0;
  logic [NB-1:0] bank_en;
  logic bank_we, pu_valid, pu_we, pu_odd, mode_err;
  logic [RW-1:0] bank_row, pu_row;
  logic [CW-1:0] bank_col, pu_col;
  logic [NB*DW-1:0] bank_wdata;
  logic [DW-1:0] rd_data;
  logic [NPU*DW-1:0] pu_rdata;
  logic [1:0] mode_o;

  int total = 0, bad = 0, m = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  pim_mode_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(c_valid), .cmd_we(c_we), .cmd_bank(c_bank),
    .cmd_row(c_row), .cmd_col(c_col), .cmd_wdata(c_wdata), .bank_rdata(b_rdata),
    .pu_wdata(p_wdata), .bank_en(bank_en), .bank_we(bank_we), .bank_row(bank_row),
    .bank_col(bank_col), .bank_wdata(bank_wdata), .rd_data(rd_data), .pu_valid(pu_valid),
    .pu_we(pu_we), .pu_odd(pu_odd), .pu_row(pu_row), .pu_col(pu_col),
    .pu_rdata(pu_rdata), .mode_o(mode_o), .mode_err(mode_err)
  );

  task automatic chk(bit ok, string req, logic [NB*DW-1:0] act, logic [NB*DW-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic fill_data();
    for (int i = 0; i < NB*DW/32; i++) b_rdata[i*32 +: 32] = $urandom;
    for (int i = 0; i < NPU*DW/32; i++) p_wdata[i*32 +: 32] = $urandom;
    for (int i = 0; i < DW/32; i++) c_wdata[i*32 +: 32] = $urandom;
  endtask

  task automatic check_cmd();
    logic [NB-1:0] e_en;
    logic [NB*DW-1:0] e_wd;
    logic [NPU*DW-1:0] e_pr;
    int sel;
    bit resv = (c_row == MROW);
    bit e_pv = c_valid && !resv && m == 2;
    for (int b = 0; b < NB; b++) begin
      e_en[b] = c_valid && !resv && (m == 0 ? (c_bank == b) : ((b % 2) == c_bank[0]));
      e_wd[b*DW +: DW] = (m == 2) ? p_wdata[(b/2)*DW +: DW] : c_wdata;
    end
    if (resv) chk(bank_en == '0, "R7", bank_en, '0);
    else if (m == 0) chk(bank_en == e_en, "R2", bank_en, e_en);
    else chk(bank_en == e_en, "R3", bank_en, e_en);
    chk(bank_wdata == e_wd, m == 2 ? "R6" : "R2", bank_wdata, e_wd);
    chk(pu_valid == e_pv, m == 2 ? "R5" : "R9", pu_valid, e_pv);
    if (c_valid && !c_we && !resv) begin
      sel = (m == 0) ? int'(c_bank) : int'(c_bank[0]);
      chk(rd_data == b_rdata[sel*DW +: DW], m == 0 ? "R10" : "R4", rd_data, b_rdata[sel*DW +: DW]);
    end
    if (e_pv) begin
      chk(pu_row == c_row && pu_col == c_col && pu_odd == c_bank[0] && pu_we == c_we,
          "R5", {pu_row, pu_col, pu_odd, pu_we}, {c_row, c_col, c_bank[0], c_we});
      if (!c_we) begin
        for (int k = 0; k < NPU; k++) e_pr[k*DW +: DW] = b_rdata[(2*k + c_bank[0])*DW +: DW];
        chk(pu_rdata == e_pr, "R5", pu_rdata, e_pr);
      end
    end
  endtask

  task automatic data_cmd(bit we, logic [3:0] bank, logic [RW-1:0] row, logic [CW-1:0] col);
    @(negedge clk);
    fill_data();
    c_valid = 1; c_we = we; c_bank = bank; c_row = row; c_col = col;
    #1 check_cmd();
  endtask

  task automatic do_mode(logic [CW-1:0] col);
    int nm = m;
    bit ill = 0;
    if (col == 0) nm = 0;
    else if (col == 1) nm = 1;
    else if (col == 2) begin if (m == 0) ill = 1; else nm = 2; end
    else ill = 1;
    @(negedge clk);
    c_valid = 1; c_we = 1; c_row = MROW; c_col = col; c_bank = 4'($urandom);
    #1 check_cmd();
    @(posedge clk); #1;
    chk(mode_o == 2'(nm), ill ? "R8" : "R7", mode_o, nm);
    chk(mode_err == ill, "R8", mode_err, ill);
    m = nm;
    @(negedge clk);
    c_valid = 0;
    @(posedge clk); #1;
    chk(mode_err == 0, "R8", mode_err, 0);
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    #1 chk(mode_o == 0 && mode_err == 0, "R1", {mode_o, mode_err}, 0);
    @(negedge clk) rst_n = 1;
    @(posedge clk); #1 chk(mode_o == 0 && mode_err == 0, "R1", {mode_o, mode_err}, 0);

    data_cmd(0, 4'd15, 14'd33, 5'd4);
    data_cmd(1, 4'd6, 14'd9, 5'd1);
    data_cmd(0, 4'd3, MROW, 5'd2);
    do_mode(5'd2);
    do_mode(5'd7);
    do_mode(5'd1);
    data_cmd(1, 4'd7, 14'd100, 5'd3);
    data_cmd(0, 4'd14, 14'd100, 5'd3);
    data_cmd(0, 4'd9, 14'd5, 5'd0);
    do_mode(5'd2);
    data_cmd(1, 4'd12, 14'd77, 5'd8);
    data_cmd(0, 4'd13, 14'd77, 5'd8);
    do_mode(5'd0);
    data_cmd(0, 4'd11, 14'd1, 5'd1);

    for (int i = 0; i < 400; i++) begin
      if ($urandom % 5 == 0) do_mode(5'($urandom % 4));
      else data_cmd(1'($urandom), 4'($urandom), RW'($urandom % 16383), 5'($urandom));
    end
    @(negedge clk) c_valid = 0;
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int n = 0; n < 100000; n++) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule